// File: doc/BRIEF.md
# Three-Wire Register Port Slave

This block is the register-port side of a three-wire control link. It listens to a serial clock, a data line that both ends can drive, and an active-low enable. Every packet carries 25 bits, most significant bit first. A 3-bit device code comes first, then a direction flag, a 5-bit register number and 16 data bits. Packets whose device code does not match are ignored. Matching write packets load one of four configuration words. Matching read packets return a status word or one of two fixed identity words.

The three serial lines come from outside the system clock domain. Each passes through a two-flop synchroniser, and clock edges are found in the system clock domain, so the serial clock must run well below the system clock. A write takes effect on the first falling serial clock edge after the enable has gone high. A write packet cut short by an early enable is dropped. On a read, the slave leaves the line undriven for the half cycle after the last address bit. It then drives sixteen bits, one per rising serial clock edge, and stops driving as soon as it sees the enable high.

The controller is a state machine:
- **Idle**: waits for the enable to go low, then moves to Header.
- **Header**: collects nine bits. On a matching device code it moves to Write-data or Turnaround, depending on the direction flag. Otherwise it moves to Skip.
- **Write-data**: collects sixteen bits. Enable high after all sixteen moves it to Commit. Enable high sooner returns it to Idle.
- **Commit**: on a falling clock edge with the enable still high, it writes and returns to Idle. If the enable goes low again first, it returns to Idle without writing.
- **Turnaround**: its first rising edge starts the drive and moves it to Read-data.
- **Read-data**: shifts out bits until the enable goes high, then returns to Idle.
- **Skip**: waits for the enable to go high, then returns to Idle.

Top module: `tws_slave`

## Requirements
- R1: A packet is sampled on rising serial clock edges, most significant bit first: device code (3 bits), then direction flag (1 = read, 0 = write), then register number (5 bits), then 16 data bits. The written word appears unchanged on the output of the register it addresses.
- R2: A packet whose device code is not binary 101 changes no register, and the data line is never driven during it.
- R3: A complete write packet updates its register only on the first falling serial clock edge after the enable has risen. While the enable is high and before that edge, the output keeps its old value.
- R4: If the enable rises before all 25 bits of a write packet have arrived, no register changes.
- R5: On a read, the output enable stays low through the turnaround half cycle. From the 10th rising edge of the packet, the slave drives data bit 15 first and changes the line only on rising edges, 16 bits in all.
- R6: Once the enable is seen high, the slave stops driving the data line.
- R7: Reading register 3 returns the 7-bit signal-strength input in bits 6:0, with bits 15:7 zero.
- R8: Reading register 30 returns 16'h825D and reading register 31 returns 16'h10B9.
- R9: Reading a write-only register (4 to 7) or an unimplemented register returns 16'h0000.
- R10: Registers 4, 5, 6 and 7 drive `cfg_o` bits [15:0], [31:16], [47:32] and [63:48] respectively. A write to any other register number changes none of them.
- R11: After reset all configuration words are zero and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sdata_i | input | 1 | Data line as seen at the pad input |
| sen_n_i | input | 1 | Active-low packet enable |
| rssi_i | input | 7 | Signal-strength value returned by register 3 |
| sdata_o | output | 1 | Data bit driven by the slave on reads |
| sdata_oe | output | 1 | Output enable for the data line pad |
| cfg_o | output | 64 | Four 16-bit configuration words, register 4 in the low word |

## Verification
The assertions check the following on every cycle:
- the line is released one cycle after the synchronised enable is high;
- the drive starts only on a rising clock edge, and a driven bit changes only on rising edges;
- a write pulse follows a high enable;
- a configuration word changes only after a write pulse addressed to registers 4 to 7.

The values of the words read back, the dropping of foreign and truncated packets, and the exact edge on which a write lands can only be shown by the bench. It compares each packet against its own register model, under random traffic and under directed corner cases.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int DEV_W   = 3;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = DEV_W + 1 + ADDR_W;
    localparam logic [DEV_W-1:0] DEV_CODE = 3'b101;
    localparam logic [31:0] ID_WORD = 32'h10B9_825D;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDAT,
        ST_COMMIT,
        ST_TURN,
        ST_RDAT,
        ST_SKIP
    } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdata_i,
    input  logic sen_n_i,
    output logic sd_s,
    output logic en_hi,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] RST_VAL = 3'b100;

    logic [LINES-1:0] pipe [STAGES];
    logic             sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
            sclk_d <= 1'b0;
        end else begin
            pipe[0] <= {sen_n_i, sdata_i, sclk_i};
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            sclk_d <= pipe[STAGES-1][0];
        end
    end

    assign sd_s      = pipe[STAGES-1][1];
    assign en_hi     = pipe[STAGES-1][2];
    assign sclk_rise = pipe[STAGES-1][0] & ~sclk_d;
    assign sclk_fall = ~pipe[STAGES-1][0] & sclk_d;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_s,
    input  logic              en_hi,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              sdo,
    output logic              oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_FULL = CNT_W'(DATA_W);

    tws_state_e        state_q, state_d;
    logic [HDR_W-2:0]  hdr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rsh_q;
    logic [DEV_W-1:0]  dev_now;
    logic              rw_now;

    assign dev_now = hdr_q[HDR_W-2 -: DEV_W];
    assign rw_now  = hdr_q[ADDR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!en_hi) state_d = ST_HDR;
            ST_HDR: begin
                if (en_hi) state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == HDR_LAST) begin
                    if (dev_now != DEV_CODE) state_d = ST_SKIP;
                    else if (rw_now)         state_d = ST_TURN;
                    else                     state_d = ST_WDAT;
                end
            end
            ST_WDAT:   if (en_hi) state_d = (cnt_q == DAT_FULL) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: if (!en_hi || sclk_fall) state_d = ST_IDLE;
            ST_TURN: begin
                if (en_hi)          state_d = ST_IDLE;
                else if (sclk_rise) state_d = ST_RDAT;
            end
            ST_RDAT:   if (en_hi) state_d = ST_IDLE;
            ST_SKIP:   if (en_hi) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            cnt_q    <= '0;
            reg_addr <= '0;
            wr_data  <= '0;
            rsh_q    <= '0;
            wr_en    <= 1'b0;
            sdo      <= 1'b0;
            oe       <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            unique case (state_q)
                ST_IDLE: cnt_q <= '0;
                ST_HDR: if (sclk_rise && !en_hi) begin
                    hdr_q <= {hdr_q[HDR_W-3:0], sd_s};
                    if (cnt_q == HDR_LAST) begin
                        reg_addr <= {hdr_q[ADDR_W-2:0], sd_s};
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WDAT: if (sclk_rise && !en_hi && cnt_q < DAT_FULL) begin
                    wr_data <= {wr_data[DATA_W-2:0], sd_s};
                    cnt_q   <= cnt_q + 1'b1;
                end
                ST_COMMIT: wr_en <= en_hi & sclk_fall;
                ST_TURN: if (sclk_rise && !en_hi) begin
                    oe    <= 1'b1;
                    sdo   <= rd_data[DATA_W-1];
                    rsh_q <= {rd_data[DATA_W-2:0], 1'b0};
                end
                ST_RDAT: if (sclk_rise && !en_hi) begin
                    sdo   <= rsh_q[DATA_W-1];
                    rsh_q <= {rsh_q[DATA_W-2:0], 1'b0};
                end
                ST_SKIP: ;
                default: ;
            endcase
            if (en_hi) oe <= 1'b0;
        end
    end
endmodule

// File: rtl/tws_regbank.sv
module tws_regbank
    import tws_pkg::*;
#(
    parameter int FIRST_WR = 4,
    parameter int NUM_WR   = 4,
    parameter int RSSI_W   = 7,
    parameter int STAT_REG = 3,
    parameter int ID_LO    = 30,
    parameter int ID_HI    = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [RSSI_W-1:0]        rssi,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_WR*DATA_W-1:0] cfg
);
    for (genvar g = 0; g < NUM_WR; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FIRST_WR + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cfg[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && addr == MY_ADDR) cfg[g*DATA_W +: DATA_W] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(STAT_REG))   rd_data = {{(DATA_W-RSSI_W){1'b0}}, rssi};
        else if (addr == ADDR_W'(ID_LO)) rd_data = ID_WORD[DATA_W-1:0];
        else if (addr == ADDR_W'(ID_HI)) rd_data = ID_WORD[2*DATA_W-1:DATA_W];
    end
endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_WR      = 4,
    parameter int RSSI_W      = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sdata_i,
    input  logic                     sen_n_i,
    input  logic [RSSI_W-1:0]        rssi_i,
    output logic                     sdata_o,
    output logic                     sdata_oe,
    output logic [NUM_WR*DATA_W-1:0] cfg_o
);
    logic              sd_s, en_hi, sclk_rise, sclk_fall, wr_en;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    tws_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .sen_n_i(sen_n_i), .sd_s(sd_s), .en_hi(en_hi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    tws_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .sd_s(sd_s), .en_hi(en_hi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
        .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en),
        .sdo(sdata_o), .oe(sdata_oe)
    );

    tws_regbank #(.NUM_WR(NUM_WR), .RSSI_W(RSSI_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
        .wr_data(wr_data), .rssi(rssi_i), .rd_data(rd_data), .cfg(cfg_o)
    );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk #(
    parameter int CFG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_hi,
    input logic             sclk_rise,
    input logic             wr_en,
    input logic [4:0]       reg_addr,
    input logic             sdata_o,
    input logic             sdata_oe,
    input logic [CFG_W-1:0] cfg_o
);
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        en_hi |=> !sdata_oe); // R6

    AST_OE_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(sclk_rise)); // R5

    AST_SDO_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(sclk_rise)) |-> $stable(sdata_o)); // R5

    AST_WR_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(en_hi)); // R3

    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> ($past(wr_en) && $past(reg_addr) >= 5'd4 && $past(reg_addr) <= 5'd7)); // R10
endmodule

bind tws_slave tws_slave_chk #(.CFG_W(NUM_WR*16)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_hi(en_hi), .sclk_rise(sclk_rise),
    .wr_en(wr_en), .reg_addr(reg_addr), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .cfg_o(cfg_o)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sen_n = 1'b1;
    logic [6:0]  rssi = '0;
    logic        sdata_o, sdata_oe;
    logic [63:0] cfg_o;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] model [4];

    always #2 clk = ~clk;

    tws_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdi),
        .sen_n_i(sen_n), .rssi_i(rssi), .sdata_o(sdata_o),
        .sdata_oe(sdata_oe), .cfg_o(cfg_o)
    );

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] a, input logic [6:0] r);
        case (a)
            5'd3:    return {9'd0, r};
            5'd30:   return 16'h825D;
            5'd31:   return 16'h10B9;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string read_req(input logic [4:0] a);
        case (a)
            5'd3:         return "R7";
            5'd30, 5'd31: return "R8";
            default:      return "R9";
        endcase
    endfunction

    // one packet of nbits bits, then enable high and one extra clock pulse
    task automatic packet(input logic [2:0] dev, input logic rw, input logic [4:0] addr,
                          input logic [15:0] data, input int nbits);
        logic [24:0] pkt;
        logic [15:0] rd;
        bit          early, any;
        bit          good, wr_ok;
        pkt   = {dev, rw, addr, data};
        rd    = '0;
        early = 1'b0;
        any   = 1'b0;
        good  = (dev == 3'b101);
        wr_ok = good && !rw && nbits == 25 && addr >= 5'd4 && addr <= 5'd7;
        sen_n = 1'b0;
        wcyc(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i < 9 || !rw) sdi = pkt[24-i];
            else              sdi = 1'b0;
            wcyc(HALF);
            if (i == 9 && sdata_oe) early = 1'b1;
            sclk = 1'b1;
            wcyc(HALF);
            if (i >= 9) rd[24-i] = sdata_oe ? sdata_o : 1'b0;
            if (sdata_oe) any = 1'b1;
            sclk = 1'b0;
        end
        wcyc(HALF);
        sen_n = 1'b1;
        wcyc(HALF);
        if (sdata_oe) any = 1'b1;
        check("R6", {63'd0, sdata_oe}, 64'd0);
        sclk = 1'b1;
        wcyc(HALF);
        if (wr_ok) check("R3", cfg_o, model_flat());
        sclk = 1'b0;
        wcyc(HALF);
        if (wr_ok) model[addr-5'd4] = data;
        if (!good) begin
            check("R2", {63'd0, any}, 64'd0);
            check("R2", cfg_o, model_flat());
        end else if (rw && nbits == 25) begin
            check("R5", {63'd0, early}, 64'd0);
            check(read_req(addr), {48'd0, rd}, {48'd0, exp_read(addr, rssi)});
        end else if (!rw && nbits < 25) begin
            check("R4", cfg_o, model_flat());
        end else if (!rw) begin
            check(wr_ok ? "R1" : "R10", cfg_o, model_flat());
        end
        wcyc(HALF);
    endtask

    initial begin
        logic [4:0] alist [10];
        int unsigned seed;
        seed = $urandom(32'd2718);
        alist = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd30, 5'd31, 5'd2, 5'd8, 5'd17};
        for (int k = 0; k < 4; k++) model[k] = '0;
        wcyc(5);
        rst_n = 1'b1;
        wcyc(5);
        check("R11", cfg_o, 64'd0);
        check("R11", {63'd0, sdata_oe}, 64'd0);

        // directed corner cases
        packet(3'b101, 1'b0, 5'd4, 16'hA5C3, 25);   // R1
        packet(3'b101, 1'b0, 5'd7, 16'h8001, 25);   // R10 top word
        packet(3'b101, 1'b1, 5'd30, 16'h0, 25);     // R8
        packet(3'b101, 1'b1, 5'd31, 16'h0, 25);     // R8
        rssi = 7'h35;
        packet(3'b101, 1'b1, 5'd3, 16'h0, 25);      // R7
        rssi = 7'h7F;
        packet(3'b101, 1'b1, 5'd3, 16'h0, 25);      // R7 all ones
        packet(3'b101, 1'b1, 5'd4, 16'h0, 25);      // R9 write-only
        packet(3'b101, 1'b0, 5'd30, 16'hFFFF, 25);  // R10 read-only write
        packet(3'b101, 1'b1, 5'd30, 16'h0, 25);     // R10 id unchanged
        packet(3'b101, 1'b0, 5'd8, 16'h1234, 25);   // R10 unimplemented
        packet(3'b101, 1'b0, 5'd5, 16'hBEEF, 20);   // R4 truncated
        packet(3'b101, 1'b0, 5'd5, 16'hBEEF, 24);   // R4 one bit short
        packet(3'b011, 1'b0, 5'd6, 16'h5555, 25);   // R2 foreign write
        packet(3'b100, 1'b1, 5'd31, 16'h0, 25);     // R2 foreign read

        // random traffic
        for (int n = 0; n < 50; n++) begin
            logic [2:0] dev;
            int nb;
            dev = ($urandom % 5 == 0) ? 3'($urandom) : 3'b101;
            nb  = ($urandom % 8 == 0) ? 5 + int'($urandom % 20) : 25;
            rssi = 7'($urandom);
            packet(dev, 1'($urandom), alist[$urandom % 10], 16'($urandom), nb);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule